// File: doc/BRIEF.md
# AXI4-Lite Secure-World Access Gate

This block sits between a single AXI4-Lite master and a small set of memory-mapped slave regions. Each region is fixed at build time as secure or non-secure. For every write and read, the gate looks at the non-secure flag in the protection field of the address channel and decides whether the transaction may reach the target region. A permitted transaction goes to its slave and the slave's own response is returned to the master. A refused transaction never reaches any slave. The gate completes it itself and returns an error code.

The read path and the write path are checked independently, each against its own protection field. An input selects which error code the gate uses for a refusal. A saturating counter of refused transactions is brought out on a side port. Each path handles one transaction at a time.

Top module: `axil_world_gate`

## Requirements
- R1: Bit 1 of the write and read protection fields is the non-secure flag (0 = secure). A secure transaction reaches any region. The region index is address bits [REGION_LSB+IDX_W-1:REGION_LSB], which are bits [13:12] by default. By default regions 0 and 2 are secure (SECURE_MAP = 4'b0101).
- R2: A non-secure transaction aimed at a non-secure region is forwarded. The slave's BRESP, RRESP and RDATA are returned to the master unchanged.
- R3: A non-secure transaction aimed at a secure region is refused, and no slave sees any VALID for it.
- R4: For a refused write, the gate accepts the AW beat and the W beat and discards the data. It then returns BRESP = 2'b10 (SLVERR) when deny_use_decerr is 0, or 2'b11 (DECERR) when it is 1. The select is sampled at the address handshake.
- R5: For a refused read, the gate returns RDATA of all zeros with RRESP coded in the same way as in R4. The select has no effect on a permitted transaction.
- R6: Once m_bvalid or m_rvalid is high, it stays high with a stable response until the master's ready is seen.
- R7: The write and read paths decide independently, each from its own protection field, and may be in flight at the same time.
- R8: deny_count is zero after reset and rises by one for each refused transaction. It saturates at its maximum value and does not wrap.
- R9: After reset, m_awready and m_arready are high, no response VALID is high, and no slave VALID is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| deny_use_decerr | input | 1 | Error select for refusals: 0 SLVERR, 1 DECERR |
| m_awaddr | input | ADDR_W | Master write address |
| m_awprot | input | 3 | Master write protection field |
| m_awvalid | input | 1 | Master write address valid |
| m_awready | output | 1 | Write address ready |
| m_wdata | input | DATA_W | Master write data |
| m_wstrb | input | DATA_W/8 | Master write strobes |
| m_wvalid | input | 1 | Master write data valid |
| m_wready | output | 1 | Write data ready |
| m_bresp | output | 2 | Write response to master |
| m_bvalid | output | 1 | Write response valid |
| m_bready | input | 1 | Master write response ready |
| m_araddr | input | ADDR_W | Master read address |
| m_arprot | input | 3 | Master read protection field |
| m_arvalid | input | 1 | Master read address valid |
| m_arready | output | 1 | Read address ready |
| m_rdata | output | DATA_W | Read data to master |
| m_rresp | output | 2 | Read response to master |
| m_rvalid | output | 1 | Read data valid |
| m_rready | input | 1 | Master read ready |
| s_awaddr | output | ADDR_W | Shared slave write address |
| s_awprot | output | 3 | Shared slave write protection |
| s_awvalid | output | NR | Per-region write address valid |
| s_awready | input | NR | Per-region write address ready |
| s_wdata | output | DATA_W | Shared slave write data |
| s_wstrb | output | DATA_W/8 | Shared slave write strobes |
| s_wvalid | output | NR | Per-region write data valid |
| s_wready | input | NR | Per-region write data ready |
| s_bresp | input | 2*NR | Per-region write responses, packed |
| s_bvalid | input | NR | Per-region write response valid |
| s_bready | output | NR | Per-region write response ready |
| s_araddr | output | ADDR_W | Shared slave read address |
| s_arprot | output | 3 | Shared slave read protection |
| s_arvalid | output | NR | Per-region read address valid |
| s_arready | input | NR | Per-region read address ready |
| s_rdata | input | DATA_W*NR | Per-region read data, packed |
| s_rresp | input | 2*NR | Per-region read responses, packed |
| s_rvalid | input | NR | Per-region read data valid |
| s_rready | output | NR | Per-region read ready |
| deny_count | output | CNT_W | Saturating count of refused transactions |

## Verification
The hardest condition to reach from the ports is saturation of the refusal counter. It takes hundreds of refused transactions, so the stimulus ends with a long loop of non-secure reads to a secure region and checks that the count has stopped at its maximum. A second hard condition is a refused write and a permitted read in flight together. The stimulus forks the two master tasks so that the two checks overlap in time. A bench slave on region 3 returns SLVERR for writes, which lets the bench tell a passed-through slave error apart from a refusal made by the gate.

// File: rtl/sec_gate_pkg.sv
package sec_gate_pkg;
  typedef logic [1:0] axi_resp_t;
  localparam axi_resp_t RESP_OKAY   = 2'b00;
  localparam axi_resp_t RESP_SLVERR = 2'b10;
  localparam axi_resp_t RESP_DECERR = 2'b11;

  function automatic axi_resp_t refusal_code(input logic use_decerr);
    return use_decerr ? RESP_DECERR : RESP_SLVERR;
  endfunction
endpackage

// File: rtl/sec_region_rule.sv
// Maps a region field and a non-secure flag to a permit decision.
module sec_region_rule #(
  parameter int NR = 4,
  parameter int IDX_W = 2,
  parameter logic [NR-1:0] SECURE_MAP = '0
) (
  input  logic [IDX_W-1:0] region_field,
  input  logic             ns_flag,
  output logic [IDX_W-1:0] region_idx,
  output logic             permit
);
  always_comb begin
    region_idx = region_field;
    permit     = !ns_flag || !SECURE_MAP[region_field];
  end
endmodule

// File: rtl/sec_deny_counter.sv
// Saturating count of refused transactions from both paths.
module sec_deny_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_wr,
  input  logic             inc_rd,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W:0] sum;

  always_comb sum = {1'b0, count} + (CNT_W+1)'(inc_wr) + (CNT_W+1)'(inc_rd);

  always_ff @(posedge clk) begin
    if (rst)            count <= '0;
    else if (sum[CNT_W]) count <= '1;
    else                count <= sum[CNT_W-1:0];
  end

  // R8: the count never goes down
  a_r8_count_monotonic: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> count >= $past(count));
  // R8: a refusal moves the count up unless it is already at its ceiling
  a_r8_count_steps: assert property (@(posedge clk) disable iff (rst)
    (inc_wr || inc_rd) && (count != '1) |=> count != $past(count));
endmodule

// File: rtl/sec_wr_path.sv
module sec_wr_path
  import sec_gate_pkg::*;
#(
  parameter int NR = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W = 2,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] m_awaddr,
  input  logic [2:0]        m_awprot,
  input  logic              m_awvalid,
  output logic              m_awready,
  input  logic [DATA_W-1:0] m_wdata,
  input  logic [STRB_W-1:0] m_wstrb,
  input  logic              m_wvalid,
  output logic              m_wready,
  output axi_resp_t         m_bresp,
  output logic              m_bvalid,
  input  logic              m_bready,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              req_permit,
  input  axi_resp_t         deny_code,
  output logic [ADDR_W-1:0] s_awaddr,
  output logic [2:0]        s_awprot,
  output logic [NR-1:0]     s_awvalid,
  input  logic [NR-1:0]     s_awready,
  output logic [DATA_W-1:0] s_wdata,
  output logic [STRB_W-1:0] s_wstrb,
  output logic [NR-1:0]     s_wvalid,
  input  logic [NR-1:0]     s_wready,
  input  logic [2*NR-1:0]   s_bresp,
  input  logic [NR-1:0]     s_bvalid,
  output logic [NR-1:0]     s_bready,
  output logic              deny_pulse
);
  typedef enum logic [2:0] {W_ADDR, W_DATA, W_SLAVE, W_SLVB, W_RESP} wr_state_t;
  wr_state_t state;

  logic [IDX_W-1:0]  idx_q;
  logic              permit_q, aw_done, w_done;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        prot_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;
  axi_resp_t         code_q, resp_q;
  logic              aw_ok, w_ok;

  always_comb begin
    aw_ok = aw_done || s_awready[idx_q];
    w_ok  = w_done  || s_wready[idx_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= W_ADDR;
      idx_q <= '0; permit_q <= 1'b0; aw_done <= 1'b0; w_done <= 1'b0;
      addr_q <= '0; prot_q <= '0; data_q <= '0; strb_q <= '0;
      code_q <= RESP_OKAY; resp_q <= RESP_OKAY;
    end else begin
      case (state)
        W_ADDR: if (m_awvalid) begin
          addr_q   <= m_awaddr;
          prot_q   <= m_awprot;
          idx_q    <= req_idx;
          permit_q <= req_permit;
          code_q   <= deny_code;
          state    <= W_DATA;
        end
        W_DATA: if (m_wvalid) begin
          data_q  <= m_wdata;
          strb_q  <= m_wstrb;
          aw_done <= 1'b0;
          w_done  <= 1'b0;
          if (permit_q) state <= W_SLAVE;
          else begin
            resp_q <= code_q;
            state  <= W_RESP;
          end
        end
        W_SLAVE: begin
          if (s_awready[idx_q]) aw_done <= 1'b1;
          if (s_wready[idx_q])  w_done  <= 1'b1;
          if (aw_ok && w_ok) state <= W_SLVB;
        end
        W_SLVB: if (s_bvalid[idx_q]) begin
          resp_q <= s_bresp[{idx_q, 1'b0} +: 2];
          state  <= W_RESP;
        end
        W_RESP: if (m_bready) state <= W_ADDR;
        default: state <= W_ADDR;
      endcase
    end
  end

  always_comb begin
    m_awready  = (state == W_ADDR);
    m_wready   = (state == W_DATA);
    m_bvalid   = (state == W_RESP);
    m_bresp    = resp_q;
    s_awaddr   = addr_q;
    s_awprot   = prot_q;
    s_wdata    = data_q;
    s_wstrb    = strb_q;
    s_awvalid  = (state == W_SLAVE && !aw_done) ? (NR'(1) << idx_q) : '0;
    s_wvalid   = (state == W_SLAVE && !w_done)  ? (NR'(1) << idx_q) : '0;
    s_bready   = (state == W_SLVB) ? (NR'(1) << idx_q) : '0;
    deny_pulse = (state == W_DATA) && m_wvalid && !permit_q;
  end

  // R4: a refused write is answered with an error code on the next cycle
  a_r4_refused_write_errors: assert property (@(posedge clk) disable iff (rst)
    deny_pulse |=> m_bvalid && (m_bresp == RESP_SLVERR || m_bresp == RESP_DECERR));
  // R6: the write response is held until the master takes it
  a_r6_bresp_held: assert property (@(posedge clk) disable iff (rst)
    m_bvalid && !m_bready |=> m_bvalid && $stable(m_bresp));
  // R3: at most one region sees a write address at a time
  a_r3_aw_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_awvalid));
endmodule

// File: rtl/sec_rd_path.sv
module sec_rd_path
  import sec_gate_pkg::*;
#(
  parameter int NR = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  m_araddr,
  input  logic [2:0]         m_arprot,
  input  logic               m_arvalid,
  output logic               m_arready,
  output logic [DATA_W-1:0]  m_rdata,
  output axi_resp_t          m_rresp,
  output logic               m_rvalid,
  input  logic               m_rready,
  input  logic [IDX_W-1:0]   req_idx,
  input  logic               req_permit,
  input  axi_resp_t          deny_code,
  output logic [ADDR_W-1:0]  s_araddr,
  output logic [2:0]         s_arprot,
  output logic [NR-1:0]      s_arvalid,
  input  logic [NR-1:0]      s_arready,
  input  logic [DATA_W*NR-1:0] s_rdata,
  input  logic [2*NR-1:0]    s_rresp,
  input  logic [NR-1:0]      s_rvalid,
  output logic [NR-1:0]      s_rready,
  output logic               deny_pulse
);
  typedef enum logic [1:0] {R_ADDR, R_SLAVE, R_SLVR, R_RESP} rd_state_t;
  rd_state_t state;

  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        prot_q;
  logic [DATA_W-1:0] data_q;
  axi_resp_t         resp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= R_ADDR;
      idx_q <= '0; addr_q <= '0; prot_q <= '0; data_q <= '0; resp_q <= RESP_OKAY;
    end else begin
      case (state)
        R_ADDR: if (m_arvalid) begin
          addr_q <= m_araddr;
          prot_q <= m_arprot;
          idx_q  <= req_idx;
          if (req_permit) state <= R_SLAVE;
          else begin
            data_q <= '0;
            resp_q <= deny_code;
            state  <= R_RESP;
          end
        end
        R_SLAVE: if (s_arready[idx_q]) state <= R_SLVR;
        R_SLVR: if (s_rvalid[idx_q]) begin
          data_q <= s_rdata[int'(idx_q)*DATA_W +: DATA_W];
          resp_q <= s_rresp[{idx_q, 1'b0} +: 2];
          state  <= R_RESP;
        end
        R_RESP: if (m_rready) state <= R_ADDR;
        default: state <= R_ADDR;
      endcase
    end
  end

  always_comb begin
    m_arready  = (state == R_ADDR);
    m_rvalid   = (state == R_RESP);
    m_rdata    = data_q;
    m_rresp    = resp_q;
    s_araddr   = addr_q;
    s_arprot   = prot_q;
    s_arvalid  = (state == R_SLAVE) ? (NR'(1) << idx_q) : '0;
    s_rready   = (state == R_SLVR)  ? (NR'(1) << idx_q) : '0;
    deny_pulse = (state == R_ADDR) && m_arvalid && !req_permit;
  end

  // R5: a refused read returns zero data with an error code
  a_r5_refused_read_zero: assert property (@(posedge clk) disable iff (rst)
    deny_pulse |=> m_rvalid && (m_rdata == '0) && m_rresp[1]);
  // R6: the read response is held until the master takes it
  a_r6_rresp_held: assert property (@(posedge clk) disable iff (rst)
    m_rvalid && !m_rready |=> m_rvalid && $stable(m_rresp) && $stable(m_rdata));
endmodule

// File: rtl/axil_world_gate.sv
module axil_world_gate
  import sec_gate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NR = 4,
  parameter int REGION_LSB = 12,
  parameter logic [NR-1:0] SECURE_MAP = 4'b0101,
  parameter int CNT_W = 8,
  localparam int IDX_W = (NR > 1) ? $clog2(NR) : 1,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 deny_use_decerr,
  input  logic [ADDR_W-1:0]    m_awaddr,
  input  logic [2:0]           m_awprot,
  input  logic                 m_awvalid,
  output logic                 m_awready,
  input  logic [DATA_W-1:0]    m_wdata,
  input  logic [STRB_W-1:0]    m_wstrb,
  input  logic                 m_wvalid,
  output logic                 m_wready,
  output logic [1:0]           m_bresp,
  output logic                 m_bvalid,
  input  logic                 m_bready,
  input  logic [ADDR_W-1:0]    m_araddr,
  input  logic [2:0]           m_arprot,
  input  logic                 m_arvalid,
  output logic                 m_arready,
  output logic [DATA_W-1:0]    m_rdata,
  output logic [1:0]           m_rresp,
  output logic                 m_rvalid,
  input  logic                 m_rready,
  output logic [ADDR_W-1:0]    s_awaddr,
  output logic [2:0]           s_awprot,
  output logic [NR-1:0]        s_awvalid,
  input  logic [NR-1:0]        s_awready,
  output logic [DATA_W-1:0]    s_wdata,
  output logic [STRB_W-1:0]    s_wstrb,
  output logic [NR-1:0]        s_wvalid,
  input  logic [NR-1:0]        s_wready,
  input  logic [2*NR-1:0]      s_bresp,
  input  logic [NR-1:0]        s_bvalid,
  output logic [NR-1:0]        s_bready,
  output logic [ADDR_W-1:0]    s_araddr,
  output logic [2:0]           s_arprot,
  output logic [NR-1:0]        s_arvalid,
  input  logic [NR-1:0]        s_arready,
  input  logic [DATA_W*NR-1:0] s_rdata,
  input  logic [2*NR-1:0]      s_rresp,
  input  logic [NR-1:0]        s_rvalid,
  output logic [NR-1:0]        s_rready,
  output logic [CNT_W-1:0]     deny_count
);
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             wr_permit, rd_permit, wr_deny, rd_deny;
  axi_resp_t        code;

  always_comb code = refusal_code(deny_use_decerr);

  sec_region_rule #(.NR(NR), .IDX_W(IDX_W), .SECURE_MAP(SECURE_MAP)) u_wr_rule (
    .region_field(m_awaddr[REGION_LSB +: IDX_W]), .ns_flag(m_awprot[1]),
    .region_idx(wr_idx), .permit(wr_permit));

  sec_region_rule #(.NR(NR), .IDX_W(IDX_W), .SECURE_MAP(SECURE_MAP)) u_rd_rule (
    .region_field(m_araddr[REGION_LSB +: IDX_W]), .ns_flag(m_arprot[1]),
    .region_idx(rd_idx), .permit(rd_permit));

  sec_wr_path #(.NR(NR), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_wr (
    .clk, .rst,
    .m_awaddr, .m_awprot, .m_awvalid, .m_awready,
    .m_wdata, .m_wstrb, .m_wvalid, .m_wready,
    .m_bresp, .m_bvalid, .m_bready,
    .req_idx(wr_idx), .req_permit(wr_permit), .deny_code(code),
    .s_awaddr, .s_awprot, .s_awvalid, .s_awready,
    .s_wdata, .s_wstrb, .s_wvalid, .s_wready,
    .s_bresp, .s_bvalid, .s_bready,
    .deny_pulse(wr_deny));

  sec_rd_path #(.NR(NR), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd (
    .clk, .rst,
    .m_araddr, .m_arprot, .m_arvalid, .m_arready,
    .m_rdata, .m_rresp, .m_rvalid, .m_rready,
    .req_idx(rd_idx), .req_permit(rd_permit), .deny_code(code),
    .s_araddr, .s_arprot, .s_arvalid, .s_arready,
    .s_rdata, .s_rresp, .s_rvalid, .s_rready,
    .deny_pulse(rd_deny));

  sec_deny_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst, .inc_wr(wr_deny), .inc_rd(rd_deny), .count(deny_count));

  // R3: a non-secure write never reaches a secure region
  a_r3_no_secure_write_fwd: assert property (@(posedge clk) disable iff (rst)
    (|(s_awvalid | s_wvalid)) |-> !(s_awprot[1] && |((s_awvalid | s_wvalid) & SECURE_MAP)));
  // R3: a non-secure read never reaches a secure region
  a_r3_no_secure_read_fwd: assert property (@(posedge clk) disable iff (rst)
    (|s_arvalid) |-> !(s_arprot[1] && |(s_arvalid & SECURE_MAP)));
endmodule

// File: tb/axil_world_gate_test.sv
`timescale 1ns/1ps
module axil_world_gate_test;
  localparam int AW = 16, DW = 32, NR = 4, CW = 8;

  logic clk = 1'b0, rst = 1'b1, sel = 1'b0;
  logic [AW-1:0] m_awaddr = '0, m_araddr = '0;
  logic [2:0] m_awprot = '0, m_arprot = '0;
  logic m_awvalid = 0, m_wvalid = 0, m_bready = 0, m_arvalid = 0, m_rready = 0;
  logic [DW-1:0] m_wdata = '0;
  logic [DW/8-1:0] m_wstrb = '1;
  logic m_awready, m_wready, m_bvalid, m_arready, m_rvalid;
  logic [1:0] m_bresp, m_rresp;
  logic [DW-1:0] m_rdata;
  logic [AW-1:0] s_awaddr, s_araddr;
  logic [2:0] s_awprot, s_arprot;
  logic [NR-1:0] s_awvalid, s_wvalid, s_bready, s_arvalid, s_rready;
  logic [DW-1:0] s_wdata;
  logic [DW/8-1:0] s_wstrb;
  logic [NR-1:0] bv, rv;
  logic [AW-1:0] ar_lat [NR];
  logic [DW*NR-1:0] s_rdata;
  logic [CW-1:0] deny_count;
  int aw_hits, ar_hits;
  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  axil_world_gate uut (
    .clk, .rst, .deny_use_decerr(sel),
    .m_awaddr, .m_awprot, .m_awvalid, .m_awready,
    .m_wdata, .m_wstrb, .m_wvalid, .m_wready,
    .m_bresp, .m_bvalid, .m_bready,
    .m_araddr, .m_arprot, .m_arvalid, .m_arready,
    .m_rdata, .m_rresp, .m_rvalid, .m_rready,
    .s_awaddr, .s_awprot, .s_awvalid, .s_awready('1),
    .s_wdata, .s_wstrb, .s_wvalid, .s_wready('1),
    .s_bresp(8'b10_00_00_00), .s_bvalid(bv), .s_bready,
    .s_araddr, .s_arprot, .s_arvalid, .s_arready('1),
    .s_rdata, .s_rresp('0), .s_rvalid(rv), .s_rready,
    .deny_count);

  // Bench slaves: region 3 answers writes with SLVERR; read data tags region and address
  always_ff @(posedge clk) begin
    if (rst) begin
      bv <= '0; rv <= '0; aw_hits <= 0; ar_hits <= 0;
      for (int i = 0; i < NR; i++) ar_lat[i] <= '0;
    end else begin
      for (int i = 0; i < NR; i++) begin
        if (bv[i] && s_bready[i]) bv[i] <= 1'b0;
        if (s_awvalid[i]) bv[i] <= 1'b1;
        if (rv[i] && s_rready[i]) rv[i] <= 1'b0;
        if (s_arvalid[i]) begin rv[i] <= 1'b1; ar_lat[i] <= s_araddr; end
      end
      if (|s_awvalid) aw_hits <= aw_hits + 1;
      if (|s_arvalid) ar_hits <= ar_hits + 1;
    end
  end

  always_comb
    for (int i = 0; i < NR; i++)
      s_rdata[i*DW +: DW] = 32'hC000_0000 | (32'(i) << 24) | {16'h0, ar_lat[i]};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic ns, input logic s,
                          input int hold, output logic [1:0] resp);
    @(negedge clk);
    sel = s; m_awaddr = a; m_awprot = {1'b0, ns, 1'b0}; m_awvalid = 1;
    while (!m_awready) @(negedge clk);
    @(negedge clk); m_awvalid = 0;
    m_wdata = 32'h5A5A_0000 | 32'(a); m_wvalid = 1;
    while (!m_wready) @(negedge clk);
    @(negedge clk); m_wvalid = 0;
    while (!m_bvalid) @(negedge clk);
    resp = m_bresp;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(m_bvalid && m_bresp == resp, "R6", "bresp held", {m_bvalid, m_bresp}, {1'b1, resp});
    end
    m_bready = 1;
    @(negedge clk); m_bready = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic ns, input logic s,
                         output logic [31:0] data, output logic [1:0] resp);
    @(negedge clk);
    sel = s; m_araddr = a; m_arprot = {1'b0, ns, 1'b0}; m_arvalid = 1;
    while (!m_arready) @(negedge clk);
    @(negedge clk); m_arvalid = 0;
    while (!m_rvalid) @(negedge clk);
    data = m_rdata; resp = m_rresp;
    m_rready = 1;
    @(negedge clk); m_rready = 0;
  endtask

  // [7]write [6]non-secure [5:4]region [3]decerr select [2]forwarded [1:0]response
  localparam logic [7:0] VEC [12] = '{
    8'b10000100, 8'b10010100, 8'b11010100, 8'b11000010,
    8'b11101011, 8'b11110110, 8'b00100100, 8'b01110100,
    8'b01100010, 8'b01001011, 8'b00001100, 8'b10101100 };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] resp, resp2;
    logic [31:0] data;
    int exp_cnt;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9: reset state
    check(m_awready && m_arready, "R9", "address readies", {m_awready, m_arready}, 2'b11);
    check(!m_bvalid && !m_rvalid, "R9", "response valids", {m_bvalid, m_rvalid}, 0);
    check(s_awvalid == 0 && s_wvalid == 0 && s_arvalid == 0, "R9", "slave valids",
          {s_awvalid, s_wvalid, s_arvalid}, 0);
    check(deny_count == 0, "R8", "count after reset", deny_count, 0);

    exp_cnt = 0;
    for (int v = 0; v < 12; v++) begin
      logic [7:0] e;
      logic [AW-1:0] a;
      int h0, exp_rd;
      e = VEC[v];
      a = AW'({e[5:4], 12'h000}) | AW'(v * 4);
      if (!e[2]) exp_cnt++;
      if (e[7]) begin
        h0 = aw_hits;
        do_write(a, e[6], e[3], 0, resp);
        check(resp == e[1:0], e[2] ? (e[6] ? "R2" : "R1") : "R4", "bresp", resp, e[1:0]);
        check(aw_hits - h0 == int'(e[2]), e[2] ? "R1" : "R3", "write forwarded", aw_hits - h0, e[2]);
      end else begin
        h0 = ar_hits;
        do_read(a, e[6], e[3], data, resp);
        exp_rd = e[2] ? (32'hC000_0000 | (32'(e[5:4]) << 24) | 32'(a)) : 0;
        check(resp == e[1:0], e[2] ? (e[6] ? "R2" : "R5") : "R5", "rresp", resp, e[1:0]);
        check(data == 32'(exp_rd), e[2] ? "R2" : "R5", "rdata", data, exp_rd);
        check(ar_hits - h0 == int'(e[2]), e[2] ? "R1" : "R3", "read forwarded", ar_hits - h0, e[2]);
      end
      check(deny_count == CW'(exp_cnt), "R8", "count step", deny_count, exp_cnt);
    end

    // R6: refused write response held while master stalls
    do_write(16'h2010, 1'b1, 1'b0, 3, resp);
    check(resp == 2'b10, "R4", "stalled refused bresp", resp, 2'b10);

    // R7: refused write and permitted read in flight together
    fork
      do_write(16'h0020, 1'b1, 1'b1, 2, resp);
      do_read(16'h1024, 1'b1, 1'b1, data, resp2);
    join
    check(resp == 2'b11, "R7", "concurrent write refused", resp, 2'b11);
    check(resp2 == 2'b00 && data == 32'hC100_1024, "R7", "concurrent read data", data, 32'hC100_1024);
    check(deny_count == CW'(exp_cnt + 2), "R8", "count after concurrent", deny_count, exp_cnt + 2);

    // R8: saturation
    for (int k = 0; k < 260; k++) do_read(16'h2000, 1'b1, 1'b0, data, resp);
    check(deny_count == 8'hFF, "R8", "saturated count", deny_count, 8'hFF);
    do_read(16'h0000, 1'b1, 1'b1, data, resp);
    check(deny_count == 8'hFF, "R8", "no wrap", deny_count, 8'hFF);
    check(resp == 2'b11 && data == 0, "R5", "refused read decerr", {data[29:0], resp}, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule